// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous request port inside the chip and an external 64K x 16 asynchronous static RAM. A request carries a word address, write data, a read/write flag and one enable bit per byte lane. The controller turns each accepted request into a complete pin-level cycle on the memory: active-low chip select, output enable, write enable and one strobe per byte lane. The bidirectional data bus is handled as three separate signals: data out, an output-enable for the pad, and data in.

The memory's nanosecond limits (access time, write pulse width, data setup, output turn-off time) are parameters. They are turned into clock-cycle counts by rounding up against the clock period, and no count is ever below one cycle. A read holds the memory in the read condition for the access count, captures the word on the edge that ends that window and returns it with a one-cycle valid pulse. It then leaves the bus undriven for the turnaround count. A write drives address, strobes and data for the pulse count and keeps all of them for one more cycle after write enable returns high. Only one request is in flight at a time, and the port accepts a new one only when the controller is idle.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, chip select, output enable, write enable and both lane strobes are high, the pad output-enable is low, the response valid is low and the request port is ready.
- R2: The request port is ready exactly when no cycle is in progress. A request is taken when valid and ready are both high at a clock edge. While the port is not ready, the request inputs have no effect on any pin.
- R3: In the cycle after a read is taken, and for the whole read window, chip select and output enable are low, write enable is high, the address equals the request address, and lane strobe i (bit 0 = data bits 7:0, bit 1 = data bits 15:8) is low exactly when enable bit i was set.
- R4: The read word is sampled on the clock edge that ends the read window. The response valid is high for exactly the one following cycle. Lanes whose enable bit was clear read back as zero.
- R5: In the cycle after a write is taken, and for the whole write window, chip select and write enable are low, output enable is high, the pad output-enable is high, data out equals the request data, and the strobes follow the enable bits as in R3. A lane with a clear enable bit keeps its stored contents.
- R6: After the write window there is exactly one cycle in which write enable is high, chip select stays low, and address, strobes, data out and pad output-enable are unchanged. The controller then goes idle.
- R7: The pad output-enable is never high while output enable is low. It rises only after output enable has been high for at least the turnaround count plus one cycle. After every read, all controls stay high for the turnaround count before the port is ready again.
- R8: Output enable and write enable are never low together. Whenever chip select is high, output enable, write enable and both strobes are high and the bus is not driven.
- R9: Each window length is the nanosecond limit divided by the clock period, rounded up, with a floor of one cycle. The write window is the larger of the pulse-width and data-setup counts. With the defaults (4 ns period; 10, 7, 5 and 4 ns), the read window is 3 cycles, the write window 2 and the turnaround 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/LANE_W | Lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | DATA_W/LANE_W | Lane strobes, active low, bit 0 = low byte |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The properties assume that the memory's real nanosecond limits fit inside the cycle counts the parameters produce, and that mem_dq_in is stable at the capture edge. The bench's memory model settles its output once per cycle, at the falling clock edge, from the pins registered at the previous rising edge, and so meets that condition. The assertions also assume the controller is the only master of the bus. The bench keeps req_valid asserted, with fields that change, through busy periods, to show that requests are taken only when the port is ready. It mixes back-to-back reads and writes so that every turnaround path is exercised.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Controller phases; the pin pattern of each phase is fixed.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_RECOVER
  } ctl_state_t;

  // Clock cycles needed to cover need_ps at a period of clk_ps, never below one.
  function automatic int unsigned span_cycles(input int unsigned need_ps,
                                              input int unsigned clk_ps);
    int unsigned n;
    n = (need_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned TA_CYC = 1,
  parameter int unsigned CNT_W  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       ready,
  output logic       accept,
  output logic       capture,
  output ctl_state_t st_nxt
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

  ctl_state_t       st_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign ready    = (st_q == ST_IDLE);
  assign accept   = ready && req_valid;
  // Edge at the end of the last read cycle samples the bus (R4).
  assign capture  = (st_q == ST_READ) && cnt_zero;

  always_comb begin
    st_nxt = st_q;
    cnt_d  = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_nxt = req_write ? ST_WRITE : ST_READ;
          cnt_d  = req_write ? WR_LAST : RD_LAST;
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          st_nxt = ST_TURN;
          cnt_d  = TA_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_zero) st_nxt = ST_IDLE;
        else          cnt_d  = cnt_q - 1'b1;
      end
      ST_WRITE: begin
        if (cnt_zero) st_nxt = ST_RECOVER;
        else          cnt_d  = cnt_q - 1'b1;
      end
      ST_RECOVER: st_nxt = ST_IDLE;
      default:    st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_state_t        st_nxt,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic [LANES-1:0]  lane_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic [LANES-1:0] lane_nxt;
  logic             sel_nxt, drive_nxt;

  assign lane_nxt  = accept ? req_be : lane_en;
  assign sel_nxt   = (st_nxt == ST_READ) || (st_nxt == ST_WRITE) || (st_nxt == ST_RECOVER);
  assign drive_nxt = (st_nxt == ST_WRITE) || (st_nxt == ST_RECOVER);

  // Control pins registered from the next phase so they leave flops directly.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= !sel_nxt;
      mem_oe_n  <= !(st_nxt == ST_READ);
      mem_we_n  <= !(st_nxt == ST_WRITE);
      mem_dq_oe <= drive_nxt;
    end
  end

  // Address, data and lane mask are latched once per request and held.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      lane_en    <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
      lane_en    <= req_be;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) mem_bs_n[g] <= 1'b1;
      else     mem_bs_n[g] <= !(sel_nxt && lane_nxt[g]);
    end
  end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= capture;
  end

  // Lanes that were not strobed return zero rather than a floating bus.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rsp_rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? mem_dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned T_ACC_PS = 10000,
  parameter int unsigned T_WP_PS  = 7000,
  parameter int unsigned T_DS_PS  = 5000,
  parameter int unsigned T_HZ_PS  = 4000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/LANE_W-1:0]   req_be,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_ce_n,
  output logic                       mem_oe_n,
  output logic                       mem_we_n,
  output logic [DATA_W/LANE_W-1:0]   mem_bs_n,
  output logic [DATA_W-1:0]          mem_dq_out,
  output logic                       mem_dq_oe,
  input  logic [DATA_W-1:0]          mem_dq_in
);

  localparam int unsigned LANES  = DATA_W / LANE_W;
  // R9: window lengths in cycles
  localparam int unsigned RD_CYC = span_cycles(T_ACC_PS, CLK_PS);
  localparam int unsigned WR_CYC = max_u(span_cycles(T_WP_PS, CLK_PS),
                                         span_cycles(T_DS_PS, CLK_PS));
  localparam int unsigned TA_CYC = span_cycles(T_HZ_PS, CLK_PS);
  localparam int unsigned MAX_CYC = max_u(RD_CYC, max_u(WR_CYC, TA_CYC));
  localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);

  ctl_state_t       st_nxt;
  logic             accept, capture;
  logic [LANES-1:0] lane_en;

  asram_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .ready     (req_ready),
    .accept    (accept),
    .capture   (capture),
    .st_nxt    (st_nxt)
  );

  asram_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .st_nxt     (st_nxt),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .lane_en    (lane_en),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_bs_n   (mem_bs_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  asram_rdcap #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_rdcap (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .lane_en   (lane_en),
    .mem_dq_in (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/asram_lane_ctrl_chk.sv
module asram_lane_ctrl_chk
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned T_ACC_PS = 10000,
  parameter int unsigned T_WP_PS  = 7000,
  parameter int unsigned T_DS_PS  = 5000,
  parameter int unsigned T_HZ_PS  = 4000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_ce_n,
  input logic                     mem_oe_n,
  input logic                     mem_we_n,
  input logic [DATA_W/LANE_W-1:0] mem_bs_n,
  input logic [DATA_W-1:0]        mem_dq_out,
  input logic                     mem_dq_oe
);

  localparam int unsigned RD_CYC  = span_cycles(T_ACC_PS, CLK_PS);
  localparam int unsigned WR_CYC  = max_u(span_cycles(T_WP_PS, CLK_PS),
                                          span_cycles(T_DS_PS, CLK_PS));
  localparam int unsigned TA_CYC  = span_cycles(T_HZ_PS, CLK_PS);
  localparam int unsigned GAP_LIM = TA_CYC + 1;
  localparam int unsigned MAX_CYC = max_u(GAP_LIM, max_u(RD_CYC, WR_CYC));
  localparam int unsigned CW      = $clog2(MAX_CYC + 3) + 1;

  logic [CW-1:0] oe_hi_cnt, oe_lo_cnt, we_lo_cnt;

  // Run-length counters for the pin windows; reset leaves the bus long idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_cnt <= CW'(GAP_LIM);
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      if (!mem_oe_n)                      oe_hi_cnt <= '0;
      else if (oe_hi_cnt < CW'(GAP_LIM))  oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (mem_oe_n)                       oe_lo_cnt <= '0;
      else if (oe_lo_cnt != '1)           oe_lo_cnt <= oe_lo_cnt + 1'b1;
      if (mem_we_n)                       we_lo_cnt <= '0;
      else if (we_lo_cnt != '1)           we_lo_cnt <= we_lo_cnt + 1'b1;
    end
  end

  AST_READY_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_dq_oe)); // R2
  AST_READ_PINS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && $past(!mem_oe_n)) |-> ($stable(mem_addr) && $stable(mem_bs_n))); // R3
  AST_READ_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_cnt >= CW'(RD_CYC))); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4
  AST_WRITE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt >= CW'(WR_CYC))); // R5
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)
                         && $stable(mem_bs_n) && $stable(mem_dq_out))); // R6
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= CW'(GAP_LIM))); // R7
  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R8
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (mem_oe_n && mem_we_n && (&mem_bs_n) && !mem_dq_oe)); // R8

endmodule

bind asram_lane_ctrl asram_lane_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .LANE_W   (LANE_W),
  .CLK_PS   (CLK_PS),
  .T_ACC_PS (T_ACC_PS),
  .T_WP_PS  (T_WP_PS),
  .T_DS_PS  (T_DS_PS),
  .T_HZ_PS  (T_HZ_PS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_bs_n   (mem_bs_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_lane_ctrl_test.sv
module asram_lane_ctrl_test;

  // Window lengths worked out by hand from the default limits (R9):
  // 10 ns / 4 ns -> 3, max(7 ns, 5 ns) / 4 ns -> 2, 4 ns / 4 ns -> 1.
  localparam int EXP_RD = 3;
  localparam int EXP_WR = 2;
  localparam int EXP_TA = 1;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be    = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_bs_n;
  logic [15:0] mem_dq_in = 16'hC0DE;

  always #5 clk = ~clk;

  asram_lane_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit armed = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- memory device model (pins only) ----------------
  logic [15:0] dev_mem [int unsigned];
  logic [15:0] ref_mem [int unsigned];

  function automatic logic [15:0] blank_word(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  always @(posedge mem_we_n) begin
    if (!rst && !mem_ce_n) begin
      logic [15:0] w;
      w = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : blank_word(mem_addr);
      for (int i = 0; i < 2; i++)
        if (!mem_bs_n[i]) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
      dev_mem[int'(mem_addr)] = w;
    end
  end

  // Bus settles once per cycle; unstrobed lanes and idle bus carry junk.
  always @(negedge clk) begin
    logic [15:0] w;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      w = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : blank_word(mem_addr);
      for (int i = 0; i < 2; i++)
        if (mem_bs_n[i]) w[i*8 +: 8] = 8'hEE;
      mem_dq_in = w;
    end else begin
      mem_dq_in = 16'hC0DE;
    end
  end

  // ---------------- cycle reference model ----------------
  typedef struct {
    logic        ce_n, oe_n, we_n, dq_oe, chk_bus, rv;
    logic [1:0]  bs_n;
    logic [15:0] addr, dout, rdata;
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic exp_t mk(input logic ce, input logic oe, input logic we,
                              input logic [1:0] bs, input logic doe, input logic cb,
                              input logic [15:0] a, input logic [15:0] d,
                              input logic rv, input logic [15:0] rd, input string tag);
    exp_t e;
    e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.bs_n = bs; e.dq_oe = doe;
    e.chk_bus = cb; e.addr = a; e.dout = d; e.rv = rv; e.rdata = rd; e.tag = tag;
    return e;
  endfunction

  function automatic logic [15:0] ref_word(input logic [15:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : blank_word(a);
  endfunction

  always @(negedge clk) begin
    if (armed && !done) begin
      exp_t e;
      bit   busy;
      busy = (q.size() > 0);
      if (busy) e = q.pop_front();
      else e = mk(1, 1, 1, 2'b11, 0, 0, '0, '0, 0, '0, "R8");
      chk("R2", "ready", req_ready, !busy);
      chk(e.tag, "ce_n", mem_ce_n, e.ce_n);
      chk(e.tag, "oe_n", mem_oe_n, e.oe_n);
      chk(e.tag, "we_n", mem_we_n, e.we_n);
      chk(e.tag, "bs_n", mem_bs_n, e.bs_n);
      chk("R7", "dq_oe", mem_dq_oe, e.dq_oe);
      chk("R4", "rsp_valid", rsp_valid, e.rv);
      if (e.chk_bus) chk(e.tag, "addr", mem_addr, e.addr);
      if (e.dq_oe)   chk(e.tag, "dq_out", mem_dq_out, e.dout);
      if (e.rv)      chk("R4", "rdata", rsp_rdata, e.rdata);
      // Request taken at the coming edge: queue its cycles.
      if (req_valid && req_ready) begin
        if (req_write) begin
          logic [15:0] w;
          for (int k = 0; k < EXP_WR; k++)
            q.push_back(mk(0, 1, 0, ~req_be, 1, 1, req_addr, req_wdata, 0, '0, "R5 R9"));
          q.push_back(mk(0, 1, 1, ~req_be, 1, 1, req_addr, req_wdata, 0, '0, "R6"));
          w = ref_word(req_addr);
          for (int i = 0; i < 2; i++)
            if (req_be[i]) w[i*8 +: 8] = req_wdata[i*8 +: 8];
          ref_mem[int'(req_addr)] = w;
        end else begin
          logic [15:0] rd;
          rd = ref_word(req_addr);
          for (int i = 0; i < 2; i++)
            if (!req_be[i]) rd[i*8 +: 8] = 8'h00;
          for (int k = 0; k < EXP_RD; k++)
            q.push_back(mk(0, 0, 1, ~req_be, 0, 1, req_addr, '0, 0, '0, "R3 R9"));
          for (int k = 0; k < EXP_TA; k++)
            q.push_back(mk(1, 1, 1, 2'b11, 0, 0, '0, '0, (k == 0), rd, "R7"));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk);
    #2;
    req_valid = 1'b0;
    req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~be;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_fail++;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      finish_up();
    end
  end

  logic [31:0] lfsr = 32'h1D2C3B4A;

  initial begin
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet pins right after reset
    chk("R1", "ce_n", mem_ce_n, 1'b1);
    chk("R1", "oe_n", mem_oe_n, 1'b1);
    chk("R1", "we_n", mem_we_n, 1'b1);
    chk("R1", "bs_n", mem_bs_n, 2'b11);
    chk("R1", "dq_oe", mem_dq_oe, 1'b0);
    chk("R1", "rsp_valid", rsp_valid, 1'b0);
    chk("R1", "ready", req_ready, 1'b1);
    armed = 1;
    @(posedge clk);
    #2;
    // Full-word write and read back (R3, R4, R5)
    issue(1, 16'h1234, 16'hBEEF, 2'b11);
    issue(0, 16'h1234, 16'h0000, 2'b11);
    idle(2);
    // Lane writes leave the other lane intact (R5)
    issue(1, 16'h1234, 16'h0011, 2'b01);
    issue(1, 16'h1234, 16'h2200, 2'b10);
    issue(0, 16'h1234, 16'h0000, 2'b11);
    // Masked reads return zero in the disabled lane (R4)
    issue(0, 16'h1234, 16'h0000, 2'b01);
    issue(0, 16'h1234, 16'h0000, 2'b10);
    issue(0, 16'h1234, 16'h0000, 2'b00);
    // No-lane write changes nothing (R5)
    issue(1, 16'h1234, 16'hFFFF, 2'b00);
    issue(0, 16'h1234, 16'h0000, 2'b11);
    // Address extremes, read-to-write turnaround (R7)
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    issue(1, 16'hFFFF, 16'hA55A, 2'b11);
    issue(1, 16'h0000, 16'h0F0F, 2'b11);
    issue(0, 16'h0000, 16'h0000, 2'b11);
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    idle(3);
    // Mixed traffic with valid kept high through busy periods (R2)
    for (int k = 0; k < 80; k++) begin
      logic [15:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[7] ? (16'hFFF0 | {12'h0, lfsr[3:0]}) : {12'h0, lfsr[3:0]};
      issue(lfsr[9], a, lfsr[31:16], lfsr[11:10]);
      if (lfsr[13] && lfsr[14]) idle(int'(lfsr[6:5]));
    end
    idle(EXP_RD + EXP_TA + 4);
    finish_up();
  end

endmodule